// File: doc/BRIEF.md
# Queue-Setup Mailbox Requester

This engine sits on the function side of a shared 256-bit mailbox and carries two commands to the managing side: one that sets up a control queue set and one that tears it down. It takes a start strobe together with an opcode, a reset request flag, four 64-bit queue base addresses (event, completion, receive, send) and an interrupt vector. It then drives a dword-wide read/write master port toward the mailbox storage.

A command runs in a fixed order. The engine first reads the mailbox's last dword until the ownership bit shows that the function side owns the mailbox. It then checks the arguments and writes the packed message. Next it reads the last dword again, pausing a programmable number of cycles between attempts, until the managing side hands ownership back. Finally it checks the reply header and ends with a one-cycle completion pulse that carries a 3-bit result code. The number of read attempts in each polling phase is bounded.

Result codes: 0 ok, 1 timeout, 2 invalid argument, 3 protocol error, 4 operation failed. Opcode 0 is set-up and opcode 1 is tear-down.

Top module: `mbreq_engine`

## Requirements
- R1: Before any write, the engine reads dword 7 until bit 31 reads 0. If that bit stays set for POLL_LIMIT reads, the command ends with code 1 and makes no write.
- R2: A set-up command whose queue addresses do not all have their low 12 bits at zero, or whose vector input has any of bits [31:16] set, ends with code 2. This happens after the ownership read and before any write. A tear-down command ignores the addresses and the vector.
- R3: Each address is shifted right by 12 to give a 52-bit frame number. Bits [47:0] of the event, completion, receive and send frame numbers occupy message bytes 0, 6, 12 and 18, in that order. Dword k holds bytes 4k to 4k+3, least significant byte first.
- R4: Message bytes 24 and 25 form a 16-bit field. Its nibble q (bits 4q+3:4q) holds bits [51:48] of frame number q, where q is 0 for event, 1 for completion, 2 for receive and 3 for send.
- R5: Bytes 26 and 27 hold vector bits [15:0]. Dword 7 is the header: bits [2:0] are the type (1 set-up, 2 tear-down), bits [5:3] are the version (0), bit 7 is the direction (0), bits [15:8] are the status (0), bit 24 is the reset flag, and every other bit is 0.
- R6: Set-up writes dwords 0 to 7 on consecutive cycles in ascending address order. Tear-down writes only dword 7.
- R7: A reply read with bit 31 clear, the type equal to the request type, a version at or below 0, direction 1 and status 0 ends with code 0.
- R8: A reply whose type differs from the request, whose version exceeds 0, or whose direction is 0 ends with code 3.
- R9: A reply that passes the R8 checks but has nonzero status ends with code 4.
- R10: With the reset flag set, a reply read of 0xFFFFFFFF ends with code 0. Without the flag, the same value counts as still owned and polling continues.
- R11: The reply phase makes at most POLL_LIMIT reads and then ends with code 1. All poll reads target dword 7. When the mailbox answers in one cycle, consecutive poll reads start poll_gap+3 cycles apart.
- R12: A start strobe while busy is high is ignored: no second completion, no change to the running command.
- R13: After reset, busy, done, both strobes and the result code are 0. The done output is a one-cycle pulse, and busy falls in the same cycle. The result code stays unchanged until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (ignored while busy) |
| op | input | 1 | 0 set-up, 1 tear-down |
| reset_req | input | 1 | Reset flag copied into the header and allowing the all-ones reply |
| evq_addr | input | 64 | Event queue base address |
| cmq_addr | input | 64 | Completion queue base address |
| rxq_addr | input | 64 | Receive queue base address |
| txq_addr | input | 64 | Send queue base address |
| irq_vec | input | 32 | Interrupt vector; only 16 bits allowed |
| poll_gap | input | 16 | Idle cycles between poll attempts |
| mb_wr_en | output | 1 | Mailbox dword write strobe |
| mb_rd_en | output | 1 | Mailbox dword read strobe |
| mb_addr | output | 3 | Mailbox dword index |
| mb_wdata | output | 32 | Write data |
| mb_rdata | input | 32 | Read data, valid with mb_rvalid |
| mb_rvalid | input | 1 | Read data valid |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | Result code, valid from done onward |

## Verification
Timing checks:
- busy rises on the edge after start.
- A read strobe appears one cycle after the engine enters a poll. The reply is seen on the next edge, and the next read follows poll_gap+2 cycles later.
- The first write strobe comes one cycle after the ownership read returns bit 31 clear.
- done arrives one edge after the deciding read data.

Because the total latency depends on how long the mailbox stays owned, the bench does not count cycles to the result. A driver pushes expected write words and result codes into queues. A monitor samples strobes and done on the falling edge and compares them as they occur. Read counts and the read-to-read spacing are measured with a cycle counter in that same falling-edge loop.

// File: rtl/mbreq_pkg.sv
package mbreq_pkg;
  typedef enum logic [2:0] {
    ERR_OK      = 3'd0,
    ERR_TIMEOUT = 3'd1,
    ERR_INVAL   = 3'd2,
    ERR_PROTO   = 3'd3,
    ERR_OPFAIL  = 3'd4
  } mb_err_e;

  localparam logic OP_SETUP    = 1'b0;
  localparam logic OP_TEARDOWN = 1'b1;

  localparam logic [2:0] TYPE_SETUP    = 3'd1;
  localparam logic [2:0] TYPE_TEARDOWN = 3'd2;
  localparam logic [2:0] REQ_VERSION   = 3'd0;

  localparam int HDR_OWNER_BIT = 31;
  localparam int DW            = 32;
endpackage

// File: rtl/mbreq_packer.sv
module mbreq_packer
  import mbreq_pkg::*;
#(
  parameter int NQ         = 4,
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int FRAME_LO   = 48,
  parameter int VEC_IN_W   = 32,
  parameter int VEC_W      = 16,
  localparam int FRAME_W   = ADDR_W - PAGE_SHIFT,
  localparam int NIB_W     = FRAME_W - FRAME_LO,
  localparam int MSG_W     = NQ * FRAME_LO + NQ * NIB_W + VEC_W + DW
) (
  input  logic [NQ-1:0][ADDR_W-1:0] addr,
  input  logic [VEC_IN_W-1:0]       vec,
  input  logic                      op,
  input  logic                      reset_req,
  output logic [MSG_W-1:0]          msg,
  output logic                      args_ok
);
  localparam int NIB_BASE = NQ * FRAME_LO;
  localparam int VEC_BASE = NIB_BASE + NQ * NIB_W;
  localparam int HDR_BASE = VEC_BASE + VEC_W;

  logic [NQ-1:0] align_ok;
  logic [DW-1:0] hdr;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic [FRAME_W-1:0] frame;
    assign frame = addr[q][ADDR_W-1:PAGE_SHIFT];
    assign msg[q*FRAME_LO +: FRAME_LO]        = frame[FRAME_LO-1:0];
    assign msg[NIB_BASE + q*NIB_W +: NIB_W]   = frame[FRAME_W-1:FRAME_LO];
    assign align_ok[q] = (addr[q][PAGE_SHIFT-1:0] == '0);
  end

  always_comb begin
    hdr        = '0;
    hdr[2:0]   = (op == OP_TEARDOWN) ? TYPE_TEARDOWN : TYPE_SETUP;
    hdr[5:3]   = REQ_VERSION;
    hdr[24]    = reset_req;
  end

  assign msg[VEC_BASE +: VEC_W] = vec[VEC_W-1:0];
  assign msg[HDR_BASE +: DW]    = hdr;
  assign args_ok = (&align_ok) && (vec[VEC_IN_W-1:VEC_W] == '0);
endmodule

// File: rtl/mbreq_reply_check.sv
module mbreq_reply_check
  import mbreq_pkg::*;
(
  input  logic [2:0] rep_type,
  input  logic [2:0] rep_ver,
  input  logic       rep_dir,
  input  logic [7:0] rep_status,
  input  logic [2:0] req_type,
  output mb_err_e    verdict
);
  always_comb begin
    if (rep_type != req_type || rep_ver > REQ_VERSION || !rep_dir)
      verdict = ERR_PROTO;
    else if (rep_status != 8'd0)
      verdict = ERR_OPFAIL;
    else
      verdict = ERR_OK;
  end
endmodule

// File: rtl/mbreq_poll_pacer.sv
module mbreq_poll_pacer #(
  parameter int POLL_LIMIT = 20000,
  parameter int GAP_W      = 16,
  localparam int CNT_W     = $clog2(POLL_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             retry,
  input  logic [GAP_W-1:0] gap,
  output logic             last_try,
  output logic             gap_done
);
  logic [CNT_W-1:0] tries;
  logic [GAP_W-1:0] gcnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tries <= '0;
    end else if (retry) begin
      tries <= tries + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt <= '0;
    end else if (retry) begin
      gcnt <= gap;
    end else if (gcnt != '0) begin
      gcnt <= gcnt - 1'b1;
    end
  end

  assign last_try = (tries == CNT_W'(POLL_LIMIT - 1));
  assign gap_done = (gcnt == '0);
endmodule

// File: rtl/mbreq_engine.sv
module mbreq_engine
  import mbreq_pkg::*;
#(
  parameter int POLL_LIMIT = 20000,
  parameter int GAP_W      = 16,
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int VEC_IN_W   = 32,
  localparam int NQ        = 4,
  localparam int MSG_W     = 256,
  localparam int NDW       = MSG_W / DW,
  localparam int IDX_W     = $clog2(NDW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op,
  input  logic              reset_req,
  input  logic [ADDR_W-1:0] evq_addr,
  input  logic [ADDR_W-1:0] cmq_addr,
  input  logic [ADDR_W-1:0] rxq_addr,
  input  logic [ADDR_W-1:0] txq_addr,
  input  logic [VEC_IN_W-1:0] irq_vec,
  input  logic [GAP_W-1:0]  poll_gap,
  output logic              mb_wr_en,
  output logic              mb_rd_en,
  output logic [IDX_W-1:0]  mb_addr,
  output logic [DW-1:0]     mb_wdata,
  input  logic [DW-1:0]     mb_rdata,
  input  logic              mb_rvalid,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NDW - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_GAP, S_WR} state_e;

  state_e                   state;
  logic                     reply_phase;
  logic [IDX_W-1:0]         idx;
  logic                     op_q, rflag_q;
  logic [NQ-1:0][ADDR_W-1:0] addr_q;
  logic [VEC_IN_W-1:0]      vec_q;
  logic [GAP_W-1:0]         gap_q;

  logic [MSG_W-1:0] msg;
  logic             args_ok;
  mb_err_e          verdict;
  logic             last_try, gap_done;

  logic    all_ones_ok, still_owned, fin, go_wr, retry;
  mb_err_e fin_code;

  mbreq_packer #(
    .NQ(NQ), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .FRAME_LO(48),
    .VEC_IN_W(VEC_IN_W), .VEC_W(16)
  ) u_pack (
    .addr(addr_q), .vec(vec_q), .op(op_q), .reset_req(rflag_q),
    .msg(msg), .args_ok(args_ok)
  );

  mbreq_reply_check u_chk_rep (
    .rep_type(mb_rdata[2:0]), .rep_ver(mb_rdata[5:3]), .rep_dir(mb_rdata[7]),
    .rep_status(mb_rdata[15:8]),
    .req_type((op_q == OP_TEARDOWN) ? TYPE_TEARDOWN : TYPE_SETUP),
    .verdict(verdict)
  );

  mbreq_poll_pacer #(.POLL_LIMIT(POLL_LIMIT), .GAP_W(GAP_W)) u_pace (
    .clk(clk), .rst(rst),
    .clr(state == S_IDLE || state == S_WR),
    .retry(retry), .gap(gap_q),
    .last_try(last_try), .gap_done(gap_done)
  );

  // decision on a returned poll read
  always_comb begin
    all_ones_ok = reply_phase && rflag_q && (&mb_rdata);
    still_owned = mb_rdata[HDR_OWNER_BIT] && !all_ones_ok;
    fin      = 1'b0;
    go_wr    = 1'b0;
    retry    = 1'b0;
    fin_code = ERR_OK;
    if (state == S_WAIT && mb_rvalid) begin
      if (all_ones_ok) begin
        fin = 1'b1;
      end else if (still_owned) begin
        if (last_try) begin
          fin      = 1'b1;
          fin_code = ERR_TIMEOUT;
        end else begin
          retry = 1'b1;
        end
      end else if (!reply_phase) begin
        if (op_q == OP_SETUP && !args_ok) begin
          fin      = 1'b1;
          fin_code = ERR_INVAL;
        end else begin
          go_wr = 1'b1;
        end
      end else begin
        fin      = 1'b1;
        fin_code = verdict;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      reply_phase <= 1'b0;
      idx         <= '0;
      op_q        <= 1'b0;
      rflag_q     <= 1'b0;
      addr_q      <= '0;
      vec_q       <= '0;
      gap_q       <= '0;
      mb_wr_en    <= 1'b0;
      mb_rd_en    <= 1'b0;
      mb_addr     <= '0;
      mb_wdata    <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      err         <= ERR_OK;
    end else begin
      done     <= 1'b0;
      mb_wr_en <= 1'b0;
      mb_rd_en <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q        <= op;
          rflag_q     <= reset_req;
          addr_q      <= {txq_addr, rxq_addr, cmq_addr, evq_addr};
          vec_q       <= irq_vec;
          gap_q       <= poll_gap;
          reply_phase <= 1'b0;
          busy        <= 1'b1;
          state       <= S_RD;
        end
        S_RD: begin
          mb_rd_en <= 1'b1;
          mb_addr  <= LAST_IDX;
          state    <= S_WAIT;
        end
        S_WAIT: begin
          if (fin) begin
            done  <= 1'b1;
            err   <= fin_code;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else if (go_wr) begin
            idx   <= (op_q == OP_TEARDOWN) ? LAST_IDX : '0;
            state <= S_WR;
          end else if (retry) begin
            state <= S_GAP;
          end
        end
        S_GAP: if (gap_done) state <= S_RD;
        S_WR: begin
          mb_wr_en <= 1'b1;
          mb_addr  <= idx;
          mb_wdata <= msg[int'(idx)*DW +: DW];
          if (idx == LAST_IDX) begin
            reply_phase <= 1'b1;
            state       <= S_RD;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbreq_chk.sv
module mbreq_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             mb_wr_en,
  input logic             mb_rd_en,
  input logic [IDX_W-1:0] mb_addr,
  input logic             busy,
  input logic             done,
  input logic [2:0]       err
);
  a_r6_wr_ascending: assert property (@(posedge clk) disable iff (rst)
    mb_wr_en && $past(mb_wr_en) |-> mb_addr == $past(mb_addr) + 1'b1);

  a_r6_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mb_wr_en && mb_rd_en));

  a_r1_wr_only_busy: assert property (@(posedge clk) disable iff (rst)
    mb_wr_en |-> busy);

  a_r11_poll_last_dword: assert property (@(posedge clk) disable iff (rst)
    mb_rd_en |-> (busy && mb_addr == '1));

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r13_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r13_err_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(err));

  a_r12_start_busy: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> (busy || done));
endmodule

bind mbreq_engine mbreq_chk #(.IDX_W(IDX_W)) u_mbreq_chk (
  .clk(clk), .rst(rst), .start(start), .mb_wr_en(mb_wr_en),
  .mb_rd_en(mb_rd_en), .mb_addr(mb_addr), .busy(busy), .done(done), .err(err)
);

// File: tb/mbreq_engine_tb.sv
module mbreq_engine_tb;
  localparam int LIM = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic        reset_req = 1'b0;
  logic [63:0] qa [4];
  logic [31:0] irq_vec = '0;
  logic [15:0] poll_gap = '0;
  logic        mb_wr_en, mb_rd_en, busy, done;
  logic [2:0]  mb_addr, err;
  logic [31:0] mb_wdata;
  logic [31:0] mb_rdata = '0;
  logic        mb_rvalid = 1'b0;

  always #10 clk = ~clk;

  mbreq_engine #(.POLL_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .reset_req(reset_req),
    .evq_addr(qa[0]), .cmq_addr(qa[1]), .rxq_addr(qa[2]), .txq_addr(qa[3]),
    .irq_vec(irq_vec), .poll_gap(poll_gap),
    .mb_wr_en(mb_wr_en), .mb_rd_en(mb_rd_en), .mb_addr(mb_addr),
    .mb_wdata(mb_wdata), .mb_rdata(mb_rdata), .mb_rvalid(mb_rvalid),
    .busy(busy), .done(done), .err(err)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0, rd_cnt = 0, done_cnt = 0;
  int rd_time [$];
  logic [34:0] exp_wr_q [$];
  logic [2:0]  exp_err_q [$];
  string       cur_req = "R13";

  // mailbox model state
  logic [31:0] cur7 = '0;
  logic [31:0] reply_cfg = '0;
  int          own_cnt = 0;
  int          reply_delay = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // mailbox responder and scoreboard monitor
  initial forever begin
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R13", "watchdog", cyc, 150000);
      finish_run();
    end
    mb_rvalid = 1'b0;
    if (mb_rd_en) begin
      rd_cnt++;
      rd_time.push_back(cyc);
      mb_rvalid = 1'b1;
      if (own_cnt > 0) begin
        mb_rdata = 32'h8000_0000;
        own_cnt--;
      end else begin
        mb_rdata = cur7;
      end
    end
    if (mb_wr_en) begin
      if (exp_wr_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected write", {mb_addr, mb_wdata}, 0);
      end else begin
        logic [34:0] e;
        e = exp_wr_q.pop_front();
        chk({mb_addr, mb_wdata} == e, cur_req, "write addr/data", {mb_addr, mb_wdata}, e);
      end
      if (mb_addr == 3'd7) begin
        cur7 = reply_cfg;
        own_cnt = reply_delay;
      end
    end
    if (done) begin
      done_cnt++;
      if (exp_err_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected done", err, 0);
      end else begin
        logic [2:0] e;
        e = exp_err_q.pop_front();
        chk(err == e, cur_req, "result code", err, e);
      end
    end
  end

  // independent message model from R3, R4, R5
  task automatic expect_writes(input bit is_down);
    logic [7:0]  b [32];
    logic [15:0] nib;
    logic [63:0] fr;
    logic [31:0] hdr;
    nib = '0;
    for (int i = 0; i < 32; i++) b[i] = 8'h00;
    for (int q = 0; q < 4; q++) begin
      fr = qa[q] >> 12;
      for (int k = 0; k < 6; k++) b[6*q+k] = fr[8*k +: 8];
      nib[4*q +: 4] = fr[51:48];
    end
    b[24] = nib[7:0];  b[25] = nib[15:8];
    b[26] = irq_vec[7:0]; b[27] = irq_vec[15:8];
    hdr = {7'd0, reset_req, 16'd0, 5'd0, (is_down ? 3'd2 : 3'd1)};
    b[28] = hdr[7:0]; b[29] = hdr[15:8]; b[30] = hdr[23:16]; b[31] = hdr[31:24];
    for (int j = 0; j < 8; j++)
      if (!is_down || j == 7)
        exp_wr_q.push_back({3'(j), b[4*j+3], b[4*j+2], b[4*j+1], b[4*j]});
  endtask

  // driver: push expectations, start, wait for completion
  task automatic run(input string req, input logic [2:0] exp_err, input bit writes,
                     input int pre_own, input logic [31:0] reply, input int delay);
    int base;
    cur_req = req;
    rd_cnt = 0;
    rd_time.delete();
    own_cnt = pre_own;
    cur7 = 32'h0000_0000;
    reply_cfg = reply;
    reply_delay = delay;
    if (writes) expect_writes(op);
    exp_err_q.push_back(exp_err);
    base = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int w = 0; w < 5000 && done_cnt == base; w++) @(negedge clk);
    chk(done_cnt == base + 1, req, "one completion", done_cnt - base, 1);
    chk(exp_wr_q.size() == 0, req, "writes outstanding", exp_wr_q.size(), 0);
    exp_wr_q.delete();
  endtask

  initial begin
    qa[0] = 64'hA123_4567_89AB_C000;
    qa[1] = 64'hB0FE_DCBA_9876_5000;
    qa[2] = 64'hC111_2222_3333_4000;
    qa[3] = 64'hD555_6666_7777_8000;
    irq_vec = 32'h0000_1234;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk({busy, done, mb_wr_en, mb_rd_en, err} == 7'd0, "R13", "reset outputs",
        {busy, done, mb_wr_en, mb_rd_en, err}, 0);

    // R3 R4 R5 R6 R7: set-up, clean reply
    op = 1'b0; reset_req = 1'b0;
    run("R3", 3'd0, 1'b1, 0, 32'h0000_0081, 0);
    chk(rd_cnt == 2, "R7", "reads", rd_cnt, 2);

    // R5 R6: tear-down with reset flag, single header write
    op = 1'b1; reset_req = 1'b1;
    run("R6", 3'd0, 1'b1, 0, 32'h0000_0082, 1);
    chk(rd_cnt == 3, "R6", "reads", rd_cnt, 3);

    // R1 R11: owned at entry, gap spacing
    op = 1'b0; reset_req = 1'b0; poll_gap = 16'd5;
    run("R1", 3'd0, 1'b1, 3, 32'h0000_0081, 2);
    chk(rd_cnt == 7, "R1", "reads", rd_cnt, 7);
    chk(rd_time[1] - rd_time[0] == 8, "R11", "poll spacing",
        rd_time[1] - rd_time[0], 8);
    poll_gap = 16'd0;

    // R13 result code held after done
    repeat (5) @(negedge clk);
    chk(err == 3'd0 && !busy, "R13", "code held", err, 0);

    // R2 misaligned, then wide vector; destroy ignores both
    qa[2] = 64'hC111_2222_3333_4010;
    run("R2", 3'd2, 1'b0, 0, 32'h0000_0081, 0);
    chk(rd_cnt == 1, "R2", "reads", rd_cnt, 1);
    qa[2] = 64'hC111_2222_3333_4000;
    irq_vec = 32'h0001_0000;
    run("R2", 3'd2, 1'b0, 0, 32'h0000_0081, 0);
    op = 1'b1;
    qa[1] = 64'hB0FE_DCBA_9876_5004;
    run("R2", 3'd0, 1'b1, 0, 32'h0000_0082, 0);
    qa[1] = 64'hB0FE_DCBA_9876_5000;
    irq_vec = 32'h0000_BEEF;

    // R8 protocol errors
    op = 1'b1;
    run("R8", 3'd3, 1'b1, 0, 32'h0000_0081, 0);
    op = 1'b0;
    run("R8", 3'd3, 1'b1, 0, 32'h0000_0089, 0);
    run("R8", 3'd3, 1'b1, 0, 32'h0000_0001, 0);

    // R9 operation failed
    run("R9", 3'd4, 1'b1, 0, 32'h0000_0581, 0);

    // R10 all-ones reply with and without reset flag
    reset_req = 1'b1;
    run("R10", 3'd0, 1'b1, 0, 32'hFFFF_FFFF, 0);
    reset_req = 1'b0;
    run("R10", 3'd1, 1'b1, 0, 32'hFFFF_FFFF, 0);
    chk(rd_cnt == 1 + LIM, "R11", "reply poll bound", rd_cnt, 1 + LIM);

    // R1 ownership never returned: timeout, no writes
    run("R1", 3'd1, 1'b0, 1000, 32'h0000_0081, 0);
    chk(rd_cnt == LIM, "R1", "pre poll bound", rd_cnt, LIM);

    // R12 start while busy ignored
    begin
      int base;
      cur_req = "R12";
      op = 1'b0; reset_req = 1'b0; poll_gap = 16'd2;
      own_cnt = 0; cur7 = 0; reply_cfg = 32'h0000_0081; reply_delay = 4;
      expect_writes(1'b0);
      exp_err_q.push_back(3'd0);
      base = done_cnt;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (4) @(negedge clk);
      op = 1'b1;
      start = 1'b1;
      @(negedge clk); start = 1'b0; op = 1'b0;
      for (int w = 0; w < 5000 && done_cnt == base; w++) @(negedge clk);
      repeat (30) @(negedge clk);
      chk(done_cnt == base + 1, "R12", "completions", done_cnt - base, 1);
      chk(exp_wr_q.size() == 0, "R12", "writes outstanding", exp_wr_q.size(), 0);
      chk(!busy, "R12", "idle after", busy, 0);
    end

    finish_run();
  end
endmodule